// File: doc/BRIEF.md
# Processor exception entry controller

This block sits next to a simple in-order pipeline and decides, once per cycle, whether the instruction in the execute stage is interrupted by an exception. Its inputs are a reset request, the two active-low interrupt pins, and the fault indications raised for the instruction in execute. When an exception is taken, the block registers the new 5-bit processor mode, the handler address, the return address and a copy of the old status word. It then pulses a save strobe and a pipeline flush together for one cycle. An outside status register uses that strobe to load the new mode and mask bits.

A fault from instruction fetch does not fire when it is raised. The block puts a tag on the fetched slot and carries that tag in a small shift chain of `DEPTH` stages. The exception is raised only when the slot reaches execute. The tag is lost if a taken branch or an exception flush empties the chain first. A data fault, an undefined instruction and a supervisor call count only when the execute slot holds a live instruction whose condition check passed.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_ni` is low, and with no clock edge needed, `mode_o` is supervisor (10011), `imask_o` and `fmask_o` are 1, `save_o` and `flush_o` are 0, `vector_o` equals `VEC_BASE`, and the return and saved-status outputs are 0.
- R2: The entry mode values are: FIQ 10001, IRQ 10010, supervisor 10011 (for a supervisor call and for a reset request), abort 10111 (for both prefetch and data faults), and undefined 11011.
- R3: An IRQ is accepted only while `irq_ni` is 0 and `cur_imask_i` is 0. An FIQ is accepted only while `fiq_ni` is 0 and `cur_fmask_i` is 0. If its mask is 1, a low pin has no effect on `save_o`.
- R4: When several exceptions qualify in one cycle, exactly one is taken. The order, highest first, is: reset request, data fault, FIQ, IRQ, prefetch fault, undefined instruction, supervisor call.
- R5: A prefetch fault presented with a valid fetch slot in cycle t is taken at the clock edge that ends cycle t+`DEPTH`, whatever the condition flag says. It is never taken if `branch_taken_i` or an exception flush empties the chain before that edge.
- R6: A data fault is taken only when the execute slot holds a valid instruction and `ex_cond_pass_i` is 1.
- R7: An undefined instruction or a supervisor call is taken only when the execute slot is valid, carries no prefetch fault tag, and `ex_cond_pass_i` is 1.
- R8: `vector_o` is `VEC_BASE` plus an offset for each kind: reset 0x00, undefined 0x04, supervisor call 0x08, prefetch fault 0x0C, data fault 0x10, IRQ 0x18, FIQ 0x1C.
- R9: On entry, `saved_status_o` holds the old status word: bit 6 is the I mask, bit 5 is the F mask, bits 4:0 are the mode. `imask_o` becomes 1. `fmask_o` becomes 1 for FIQ and for a reset request, and keeps `cur_fmask_i` for every other kind.
- R10: `ret_addr_o` is `ex_pc_i` + `PC_STEP` for a supervisor call, 0 for a reset request, and `ex_pc_i` for every other kind.
- R11: `save_o` and `flush_o` rise together for exactly one cycle. That cycle follows the decision cycle and is the same cycle in which the new mode appears. No exception is accepted during that flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reset_req_i | input | 1 | Synchronous reset exception request |
| irq_ni | input | 1 | Interrupt request pin, active low |
| fiq_ni | input | 1 | Fast interrupt request pin, active low |
| fetch_valid_i | input | 1 | A fetched slot enters the tag chain this cycle |
| fetch_pabt_i | input | 1 | The entering slot carries a prefetch fault |
| branch_taken_i | input | 1 | Branch in execute; empties the younger slots |
| ex_cond_pass_i | input | 1 | The execute instruction passed its condition check |
| ex_dabt_i | input | 1 | Data access fault for the execute instruction |
| ex_undef_i | input | 1 | The execute instruction was not recognised |
| ex_svc_i | input | 1 | The execute instruction is a supervisor call |
| ex_pc_i | input | ADDR_W | Address of the execute instruction |
| cur_mode_i | input | 5 | Current mode field of the status word |
| cur_imask_i | input | 1 | Current I mask bit |
| cur_fmask_i | input | 1 | Current F mask bit |
| mode_o | output | 5 | Mode to enter |
| imask_o | output | 1 | New I mask bit |
| fmask_o | output | 1 | New F mask bit |
| vector_o | output | ADDR_W | Handler address |
| ret_addr_o | output | ADDR_W | Return address to save |
| saved_status_o | output | 7 | Old status word {I, F, mode} |
| save_o | output | 1 | One-cycle strobe to load the outputs above |
| flush_o | output | 1 | One-cycle pipeline flush |

## Verification
A tag chain that holds a stale prefetch fault shows at the ports as an unexpected strobe with vector offset 0x0C, exactly `DEPTH` cycles after the fetch or the branch that should have removed it. A fault in the priority pick or in the qualification logic shows in the first cycle after the decision, as the wrong mode, the wrong vector offset or a missing strobe. A flush register that does not clear shows as a second strobe in the next cycle, or as an interrupt taken again while the mask is still being written back.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;

   typedef enum logic [4:0] {
      MODE_USR = 5'b10000,
      MODE_FIQ = 5'b10001,
      MODE_IRQ = 5'b10010,
      MODE_SVC = 5'b10011,
      MODE_MON = 5'b10110,
      MODE_ABT = 5'b10111,
      MODE_HYP = 5'b11010,
      MODE_UND = 5'b11011,
      MODE_SYS = 5'b11111
   } cpu_mode_e;

   typedef enum logic [2:0] {
      EXC_NONE,
      EXC_RST,
      EXC_DABT,
      EXC_FIQ,
      EXC_IRQ,
      EXC_PABT,
      EXC_UND,
      EXC_SVC
   } exc_kind_e;

   typedef struct packed {
      logic valid;
      logic pabt;
   } slot_tag_t;

   localparam int unsigned VEC_OFS_W = 5;
   localparam int unsigned STATUS_W  = 7;

   function automatic logic [VEC_OFS_W-1:0] vec_offset(exc_kind_e k);
      case (k)
         EXC_UND:  return 5'h04;
         EXC_SVC:  return 5'h08;
         EXC_PABT: return 5'h0C;
         EXC_DABT: return 5'h10;
         EXC_IRQ:  return 5'h18;
         EXC_FIQ:  return 5'h1C;
         default:  return 5'h00;
      endcase
   endfunction

   function automatic cpu_mode_e entry_mode(exc_kind_e k);
      case (k)
         EXC_FIQ:             return MODE_FIQ;
         EXC_IRQ:             return MODE_IRQ;
         EXC_PABT, EXC_DABT:  return MODE_ABT;
         EXC_UND:             return MODE_UND;
         default:             return MODE_SVC;
      endcase
   endfunction

endpackage

// File: rtl/exc_tag_pipe.sv
`timescale 1ns/1ps
module exc_tag_pipe
   import exc_entry_pkg::*;
#(
   parameter int unsigned DEPTH = 2
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      kill_i,
   input  slot_tag_t fetch_tag_i,
   output slot_tag_t exec_tag_o
);

   slot_tag_t [DEPTH-1:0] stage_q;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("exc_tag_pipe: DEPTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     stage_q <= '0;
            else if (kill_i) stage_q <= '0;
            else             stage_q <= fetch_tag_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     stage_q <= '0;
            else if (kill_i) stage_q <= '0;
            else             stage_q <= {stage_q[DEPTH-2:0], fetch_tag_i};
         end
      end
   endgenerate

   assign exec_tag_o = stage_q[DEPTH-1];

   // a kill leaves no live slot in execute on the following cycle
   assert_kill_empties_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      kill_i |=> !exec_tag_o.valid);

endmodule

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter
   import exc_entry_pkg::*;
(
   input  logic      hold_i,
   input  logic      reset_req_i,
   input  logic      irq_ni,
   input  logic      fiq_ni,
   input  logic      cur_imask_i,
   input  logic      cur_fmask_i,
   input  slot_tag_t exec_tag_i,
   input  logic      cond_pass_i,
   input  logic      dabt_i,
   input  logic      undef_i,
   input  logic      svc_i,
   output exc_kind_e kind_o
);

   logic live, req_dabt, req_fiq, req_irq, req_pabt, req_und, req_svc;

   assign live     = exec_tag_i.valid;
   assign req_dabt = live & cond_pass_i & dabt_i;
   assign req_fiq  = ~fiq_ni & ~cur_fmask_i;
   assign req_irq  = ~irq_ni & ~cur_imask_i;
   assign req_pabt = live & exec_tag_i.pabt;
   assign req_und  = live & ~exec_tag_i.pabt & cond_pass_i & undef_i;
   assign req_svc  = live & ~exec_tag_i.pabt & cond_pass_i & svc_i;

   always_comb begin
      kind_o = EXC_NONE;
      if (hold_i)           kind_o = EXC_NONE;
      else if (reset_req_i) kind_o = EXC_RST;
      else if (req_dabt)    kind_o = EXC_DABT;
      else if (req_fiq)     kind_o = EXC_FIQ;
      else if (req_irq)     kind_o = EXC_IRQ;
      else if (req_pabt)    kind_o = EXC_PABT;
      else if (req_und)     kind_o = EXC_UND;
      else if (req_svc)     kind_o = EXC_SVC;
   end

endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int unsigned      ADDR_W   = 32,
   parameter int unsigned      DEPTH    = 2,
   parameter int unsigned      PC_STEP  = 4,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reset_req_i,
   input  logic              irq_ni,
   input  logic              fiq_ni,
   input  logic              fetch_valid_i,
   input  logic              fetch_pabt_i,
   input  logic              branch_taken_i,
   input  logic              ex_cond_pass_i,
   input  logic              ex_dabt_i,
   input  logic              ex_undef_i,
   input  logic              ex_svc_i,
   input  logic [ADDR_W-1:0] ex_pc_i,
   input  logic [4:0]        cur_mode_i,
   input  logic              cur_imask_i,
   input  logic              cur_fmask_i,
   output logic [4:0]        mode_o,
   output logic              imask_o,
   output logic              fmask_o,
   output logic [ADDR_W-1:0] vector_o,
   output logic [ADDR_W-1:0] ret_addr_o,
   output logic [STATUS_W-1:0] saved_status_o,
   output logic              save_o,
   output logic              flush_o
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("exc_entry_ctrl: ADDR_W must be at least 8");
      end
      if (VEC_BASE[VEC_OFS_W-1:0] != '0) begin : g_bad_base
         $error("exc_entry_ctrl: VEC_BASE must be 32-byte aligned");
      end
      if (PC_STEP == 0) begin : g_bad_step
         $error("exc_entry_ctrl: PC_STEP must be non-zero");
      end
   endgenerate

   slot_tag_t  fetch_tag, exec_tag;
   exc_kind_e  take_kind;
   logic       take, kill, flush_q;
   cpu_mode_e  mode_q;
   logic       imask_q, fmask_q;
   logic [ADDR_W-1:0] vector_q, ret_q, ret_d;
   logic [STATUS_W-1:0] spsr_q;

   assign fetch_tag = '{valid: fetch_valid_i, pabt: fetch_valid_i & fetch_pabt_i};
   assign take      = (take_kind != EXC_NONE);
   assign kill      = branch_taken_i | take | flush_q;

   exc_tag_pipe #(.DEPTH(DEPTH)) u_tags (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .kill_i      (kill),
      .fetch_tag_i (fetch_tag),
      .exec_tag_o  (exec_tag)
   );

   exc_arbiter u_arb (
      .hold_i      (flush_q),
      .reset_req_i (reset_req_i),
      .irq_ni      (irq_ni),
      .fiq_ni      (fiq_ni),
      .cur_imask_i (cur_imask_i),
      .cur_fmask_i (cur_fmask_i),
      .exec_tag_i  (exec_tag),
      .cond_pass_i (ex_cond_pass_i),
      .dabt_i      (ex_dabt_i),
      .undef_i     (ex_undef_i),
      .svc_i       (ex_svc_i),
      .kind_o      (take_kind)
   );

   always_comb begin
      case (take_kind)
         EXC_RST: ret_d = '0;
         EXC_SVC: ret_d = ex_pc_i + STEP;
         default: ret_d = ex_pc_i;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flush_q  <= 1'b0;
         mode_q   <= MODE_SVC;
         imask_q  <= 1'b1;
         fmask_q  <= 1'b1;
         vector_q <= VEC_BASE;
         ret_q    <= '0;
         spsr_q   <= '0;
      end else begin
         flush_q <= take;
         if (take) begin
            mode_q   <= entry_mode(take_kind);
            imask_q  <= 1'b1;
            fmask_q  <= (take_kind == EXC_FIQ || take_kind == EXC_RST) ? 1'b1 : cur_fmask_i;
            vector_q <= VEC_BASE + ADDR_W'(vec_offset(take_kind));
            ret_q    <= ret_d;
            spsr_q   <= {cur_imask_i, cur_fmask_i, cur_mode_i};
         end
      end
   end

   assign mode_o         = mode_q;
   assign imask_o        = imask_q;
   assign fmask_o        = fmask_q;
   assign vector_o       = vector_q;
   assign ret_addr_o     = ret_q;
   assign saved_status_o = spsr_q;
   assign save_o         = flush_q;
   assign flush_o        = flush_q;

   assert_flush_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o |=> !flush_o);

   assert_entry_imask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      save_o |-> imask_o);

   assert_irq_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (save_o && mode_o == MODE_IRQ) |-> $past(!irq_ni && !cur_imask_i));

   assert_fiq_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (save_o && mode_o == MODE_FIQ) |-> ($past(!fiq_ni && !cur_fmask_i) && fmask_o));

   assert_irq_below_fiq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (save_o && mode_o == MODE_IRQ) |-> $past((fiq_ni || cur_fmask_i) && !reset_req_i));

   assert_fiq_vector_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (save_o && mode_o == MODE_FIQ) |-> (vector_o == VEC_BASE + ADDR_W'(5'h1C)));

endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;

   localparam int unsigned     AW    = 32;
   localparam int unsigned     DEPTH = 2;
   localparam logic [AW-1:0]   BASE  = 32'h0000_0100;
   localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                          M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                          M_SYS = 5'b11111;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reset_req, irq_n, fiq_n, f_valid, f_pabt, branch, cond, dabt, undef, svc;
   logic [AW-1:0] pc;
   logic [4:0] cur_mode;
   logic cur_i, cur_f;
   logic [4:0] mode_o;
   logic imask_o, fmask_o, save_o, flush_o;
   logic [AW-1:0] vector_o, ret_o;
   logic [6:0] spsr_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   exc_entry_ctrl #(.ADDR_W(AW), .DEPTH(DEPTH), .PC_STEP(4), .VEC_BASE(BASE)) dut (
      .clk_i(clk), .rst_ni(rst_n), .reset_req_i(reset_req), .irq_ni(irq_n), .fiq_ni(fiq_n),
      .fetch_valid_i(f_valid), .fetch_pabt_i(f_pabt), .branch_taken_i(branch),
      .ex_cond_pass_i(cond), .ex_dabt_i(dabt), .ex_undef_i(undef), .ex_svc_i(svc),
      .ex_pc_i(pc), .cur_mode_i(cur_mode), .cur_imask_i(cur_i), .cur_fmask_i(cur_f),
      .mode_o(mode_o), .imask_o(imask_o), .fmask_o(fmask_o), .vector_o(vector_o),
      .ret_addr_o(ret_o), .saved_status_o(spsr_o), .save_o(save_o), .flush_o(flush_o)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic quiet();
      reset_req = 1'b0; irq_n = 1'b1; fiq_n = 1'b1; f_valid = 1'b0; f_pabt = 1'b0;
      branch = 1'b0; cond = 1'b1; dabt = 1'b0; undef = 1'b0; svc = 1'b0;
   endtask

   initial begin
      #(64'd20 * 64'd150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic rr, dab, fl, il, im, fm, p, un, sv, cnd;
      int   kind;
      logic [4:0] em;
      logic [7:0] eo;
      logic [AW-1:0] elr;

      quiet();
      pc = 32'h1000; cur_mode = M_USR; cur_i = 1'b0; cur_f = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 reset mode", mode_o, M_SVC);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 mode", mode_o, M_SVC);
      chk("R1 masks", {imask_o, fmask_o}, 2'b11);
      chk("R1 strobes", {save_o, flush_o}, 2'b00);
      chk("R1 vector", vector_o, BASE);

      // R3: masked interrupt pins are ignored
      cur_i = 1'b1; cur_f = 1'b1; irq_n = 1'b0; fiq_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R3 masked pins ignored", save_o, 1'b0);
      end
      fiq_n = 1'b1; cur_i = 1'b0;
      @(negedge clk);
      chk("R3 IRQ taken", save_o, 1'b1);
      chk("R3 IRQ mode", mode_o, M_IRQ);
      chk("R8 IRQ vector", vector_o, BASE + 32'h18);
      chk("R9 F kept for IRQ", fmask_o, 1'b1);
      irq_n = 1'b1; cur_i = 1'b1;
      @(negedge clk);
      chk("R11 pulse ends", save_o, 1'b0);
      cur_f = 1'b0; fiq_n = 1'b0; pc = 32'h1234;
      @(negedge clk);
      chk("R3 FIQ taken", {save_o, mode_o}, {1'b1, M_FIQ});
      chk("R8 FIQ vector", vector_o, BASE + 32'h1C);
      chk("R10 FIQ return", ret_o, 32'h1234);
      fiq_n = 1'b1; cur_f = 1'b1;
      @(negedge clk);
      cur_i = 1'b0; cur_f = 1'b0;

      // R5: tag reaches execute after DEPTH cycles, condition ignored
      f_valid = 1'b1; f_pabt = 1'b1; cond = 1'b0;
      @(negedge clk);
      f_valid = 1'b0; f_pabt = 1'b0;
      repeat (DEPTH - 1) @(negedge clk);
      chk("R5 not yet at execute", save_o, 1'b0);
      @(negedge clk);
      chk("R5 prefetch fault taken", {save_o, mode_o}, {1'b1, M_ABT});
      chk("R5 prefetch vector", vector_o, BASE + 32'h0C);
      cond = 1'b1;
      repeat (2) @(negedge clk);

      // R5: branch removes a tagged slot
      f_valid = 1'b1; f_pabt = 1'b1;
      @(negedge clk);
      f_valid = 1'b0; f_pabt = 1'b0; branch = 1'b1;
      @(negedge clk);
      branch = 1'b0;
      for (int k = 0; k < DEPTH + 1; k++) begin
         @(negedge clk);
         chk("R5 dropped by branch", save_o, 1'b0);
      end

      // R5: an earlier interrupt flush removes a tagged slot
      f_valid = 1'b1; f_pabt = 1'b1;
      @(negedge clk);
      f_valid = 1'b0; f_pabt = 1'b0; irq_n = 1'b0;
      @(negedge clk);
      chk("R5 interrupt first", {save_o, mode_o}, {1'b1, M_IRQ});
      irq_n = 1'b1; cur_i = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R5 dropped by flush", save_o, 1'b0);
      end
      cur_i = 1'b0;

      // R6 / R7: faults with an empty execute slot
      dabt = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R6 data fault without live slot", save_o, 1'b0);
      dabt = 1'b0; undef = 1'b1; svc = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R7 undef/svc without live slot", save_o, 1'b0);
      undef = 1'b0; svc = 1'b0;

      // R11: held unmasked IRQ with unchanged mask: strobe every other cycle
      irq_n = 1'b0;
      @(negedge clk);
      chk("R11 first strobe", {save_o, flush_o}, 2'b11);
      @(negedge clk);
      chk("R11 blocked during flush", {save_o, flush_o}, 2'b00);
      @(negedge clk);
      chk("R11 second strobe", save_o, 1'b1);
      irq_n = 1'b1; cur_i = 1'b1;
      @(negedge clk);

      // R1: asynchronous reset
      rst_n = 1'b0;
      #1;
      chk("R1 async reset", {mode_o, imask_o, fmask_o, save_o}, {M_SVC, 3'b110});
      @(negedge clk);
      rst_n = 1'b1; cur_i = 1'b0;
      repeat (2) @(negedge clk);

      // exhaustive sweep over qualifying inputs
      for (int v = 0; v < 1024; v++) begin
         rr = v[0]; dab = v[1]; fl = v[2]; il = v[3]; im = v[4];
         fm = v[5]; p = v[6]; un = v[7]; sv = v[8]; cnd = v[9];
         cur_i = im; cur_f = fm;
         cur_mode = (v % 3 == 0) ? M_USR : ((v % 3 == 1) ? M_SYS : M_SVC);
         pc = 32'h2000 + 32'(v) * 4;
         f_valid = 1'b1; f_pabt = p;
         @(negedge clk);
         f_valid = 1'b0; f_pabt = 1'b0;
         repeat (DEPTH - 1) @(negedge clk);
         reset_req = rr; dabt = dab; fiq_n = ~fl; irq_n = ~il;
         undef = un; svc = sv; cond = cnd;
         @(negedge clk);
         if (rr)              begin kind = 1; em = M_SVC; eo = 8'h00; end
         else if (dab && cnd) begin kind = 2; em = M_ABT; eo = 8'h10; end
         else if (fl && !fm)  begin kind = 3; em = M_FIQ; eo = 8'h1C; end
         else if (il && !im)  begin kind = 4; em = M_IRQ; eo = 8'h18; end
         else if (p)          begin kind = 5; em = M_ABT; eo = 8'h0C; end
         else if (un && cnd)  begin kind = 6; em = M_UND; eo = 8'h04; end
         else if (sv && cnd)  begin kind = 7; em = M_SVC; eo = 8'h08; end
         else                 begin kind = 0; em = M_SVC; eo = 8'h00; end
         elr = (kind == 1) ? '0 : ((kind == 7) ? pc + 4 : pc);
         chk("R4 R6 R7 sweep strobe", save_o, kind != 0);
         chk("R11 sweep flush with strobe", flush_o, kind != 0);
         if (kind != 0) begin
            chk("R2 sweep mode", mode_o, em);
            chk("R8 sweep vector", vector_o, BASE + 32'(eo));
            chk("R9 sweep masks", {imask_o, fmask_o},
                {1'b1, (kind == 1 || kind == 3) ? 1'b1 : fm});
            chk("R9 sweep saved status", spsr_o, {im, fm, cur_mode});
            chk("R10 sweep return", ret_o, elr);
         end
         quiet();
         @(negedge clk);
         chk("R11 sweep single pulse", flush_o, 1'b0);
         @(negedge clk);
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule